// File: doc/BRIEF.md
# PWM Fault Trip Guard

This block sits between a PWM generator and the output pads. It watches an active-low fault pin. When the pin asserts, or when software forces a fault, it replaces each of the two PWM outputs with a programmed safe state. The safe state can be a high level, a low level, the unchanged PWM level, or a released pad with its output enable low.

Two kinds of trip are provided, and each has its own select bit.

- A one-shot trip latches. It holds the outputs in the safe state until software clears its flag.
- A cycle-by-cycle trip releases by itself. It clears at the first counter-zero strobe that arrives after the pin has gone back to its idle level, so a fault that persists keeps the outputs tripped period after period.

Event flags, a latched interrupt with a separate enable per trip kind, write-one-to-clear strobes and force strobes are all reached through a small write port.

There is no streaming data path, so no valid/ready handshake is used. Every pin is plain control or status. A register write takes effect at the clock edge where `wr_en` is sampled high, and the port never stalls.

Register map on `wr_addr` (all registers reset to 0):

- Address 0 holds the trip-source selects. Bit 0 enables the cycle-by-cycle source and bit 1 enables the one-shot source.
- Address 1 holds the trip actions. Bits [1:0] set output A and bits [3:2] set output B.
- Address 2 holds the interrupt enables. Bit 0 is for cycle-by-cycle events and bit 1 for one-shot events.
- Address 3 is a clear strobe. Bit 0 clears the cycle-by-cycle flag, bit 1 clears the one-shot flag and bit 2 clears the interrupt.
- Address 4 is a force strobe. Bit 0 forces a cycle-by-cycle event and bit 1 forces a one-shot event.

Top module: `pwm_trip_guard`

## Requirements
- R1: After reset, both outputs follow their PWM inputs with output enable high, and `os_flag`, `cyc_flag` and `irq` are 0.
- R2: The fault pin passes through a two-flop synchronizer. A trip caused by the pin takes effect on the outputs after the third rising clock edge following the pin going low, and not after the second.
- R3: A one-shot trip, once set, persists even after the pin returns high and counter-zero strobes occur. It ends only when a 1 is written to bit 1 at address 3.
- R4: A cycle-by-cycle trip ends at a counter-zero strobe only if the synchronized pin is no longer asserted. A counter-zero strobe while the pin is still low leaves the outputs tripped.
- R5: While tripped, each output applies its 2-bit action code: 0 drives the output low with output enable low, 1 drives high, 2 drives low, and 3 passes the PWM input through. Whenever an output is driven, its output enable is high.
- R6: With both select bits at 0, the fault pin changes neither the outputs nor any flag.
- R7: `cyc_flag` sets on a cycle-by-cycle event and stays set after the automatic release. It clears only when a 1 is written to bit 0 at address 3. Writing 0 to address 3 clears nothing.
- R8: `irq` sets only on an event whose enable bit is set at address 2. An event that is not enabled leaves `irq` at 0.
- R9: Once set, `irq` stays set, even after the trip flags are cleared, until a 1 is written to bit 2 at address 3.
- R10: Writing 1 to bit 1 or bit 0 at address 4 raises a one-shot or a cycle-by-cycle event, whatever the select bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_a_in | input | 1 | Raw PWM output A |
| pwm_b_in | input | 1 | Raw PWM output B |
| trip_n | input | 1 | Asynchronous fault pin, active low |
| ctr_zero | input | 1 | One-cycle strobe at PWM counter zero |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 4 | Register write data |
| pwm_a_out | output | 1 | Protected output A |
| pwm_a_oe | output | 1 | Output enable for A |
| pwm_b_out | output | 1 | Protected output B |
| pwm_b_oe | output | 1 | Output enable for B |
| os_flag | output | 1 | One-shot trip flag, which is also the one-shot trip state |
| cyc_flag | output | 1 | Cycle-by-cycle event flag |
| irq | output | 1 | Latched trip interrupt |

## Verification
A wrong trip state shows up at once as the wrong level or the wrong output enable on the protected outputs.

- A lost one-shot latch releases the outputs at the first counter-zero strobe.
- A stuck cycle-by-cycle state keeps them tripped after a strobe that should have released them.
- An off-by-one in the synchronizer moves the first tripped cycle one edge earlier or later. The bench checks both neighbouring edges to catch this.
- Flag and interrupt faults appear on their own pins, either on the edge of the clearing write or on the edge of the event.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;

  // Safe-state codes for a tripped output
  typedef enum logic [1:0] {
    TRIP_HIZ  = 2'd0,
    TRIP_HIGH = 2'd1,
    TRIP_LOW  = 2'd2,
    TRIP_KEEP = 2'd3
  } trip_act_e;

  localparam int REG_SEL = 0;
  localparam int REG_ACT = 1;
  localparam int REG_IEN = 2;
  localparam int REG_CLR = 3;
  localparam int REG_FRC = 4;

  localparam int BIT_CYC = 0;
  localparam int BIT_OS  = 1;
  localparam int BIT_IRQ = 2;

endpackage

// File: rtl/trip_sync.sv
module trip_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fault
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= pin_n;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign fault = ~chain_q[STAGES-1];
endmodule

// File: rtl/trip_core.sv
module trip_core (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  input  logic sel_cyc,
  input  logic sel_os,
  input  logic ie_cyc,
  input  logic ie_os,
  input  logic frc_cyc,
  input  logic frc_os,
  input  logic clr_cyc,
  input  logic clr_os,
  input  logic clr_irq,
  input  logic ctr_zero,
  output logic os_state,
  output logic cyc_state,
  output logic cyc_flag,
  output logic irq
);
  logic os_evt, cyc_evt, irq_evt;
  logic os_q, cyc_q, cyc_flag_q, irq_q;

  assign os_evt  = (sel_os  & fault) | frc_os;
  assign cyc_evt = (sel_cyc & fault) | frc_cyc;
  assign irq_evt = (os_evt & ie_os) | (cyc_evt & ie_cyc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_q       <= 1'b0;
      cyc_q      <= 1'b0;
      cyc_flag_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      // a new event outranks a clear in the same cycle
      if (os_evt)       os_q <= 1'b1;
      else if (clr_os)  os_q <= 1'b0;

      if (cyc_evt)       cyc_q <= 1'b1;
      else if (ctr_zero) cyc_q <= 1'b0;

      if (cyc_evt)      cyc_flag_q <= 1'b1;
      else if (clr_cyc) cyc_flag_q <= 1'b0;

      // the interrupt re-arms only after it has been cleared
      if (irq_q) irq_q <= ~clr_irq;
      else       irq_q <= irq_evt;
    end
  end

  assign os_state  = os_q;
  assign cyc_state = cyc_q;
  assign cyc_flag  = cyc_flag_q;
  assign irq       = irq_q;
endmodule

// File: rtl/trip_out_stage.sv
module trip_out_stage
  import pwm_trip_pkg::*;
(
  input  logic       tripped,
  input  logic [1:0] act,
  input  logic       pwm_in,
  output logic       pwm_out,
  output logic       pwm_oe
);
  always_comb begin
    pwm_out = pwm_in;
    pwm_oe  = 1'b1;
    if (tripped) begin
      unique case (trip_act_e'(act))
        TRIP_HIZ:  begin pwm_out = 1'b0; pwm_oe = 1'b0; end
        TRIP_HIGH: pwm_out = 1'b1;
        TRIP_LOW:  pwm_out = 1'b0;
        TRIP_KEEP: pwm_out = pwm_in;
        default:   pwm_out = pwm_in;
      endcase
    end
  end
endmodule

// File: rtl/pwm_trip_guard.sv
module pwm_trip_guard
  import pwm_trip_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_OUT     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_a_in,
  input  logic              pwm_b_in,
  input  logic              trip_n,
  input  logic              ctr_zero,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_a_out,
  output logic              pwm_a_oe,
  output logic              pwm_b_out,
  output logic              pwm_b_oe,
  output logic              os_flag,
  output logic              cyc_flag,
  output logic              irq
);
  localparam int ACT_W = 2 * NUM_OUT;

  logic [1:0]       sel_q, ien_q;
  logic [ACT_W-1:0] act_q;
  logic             wr_sel, wr_act, wr_ien, wr_clr, wr_frc;
  logic             fault, os_state, cyc_state, tripped;
  logic [NUM_OUT-1:0] pin_v, out_v, oe_v;

  assign wr_sel = wr_en && (wr_addr == ADDR_W'(REG_SEL));
  assign wr_act = wr_en && (wr_addr == ADDR_W'(REG_ACT));
  assign wr_ien = wr_en && (wr_addr == ADDR_W'(REG_IEN));
  assign wr_clr = wr_en && (wr_addr == ADDR_W'(REG_CLR));
  assign wr_frc = wr_en && (wr_addr == ADDR_W'(REG_FRC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      act_q <= '0;
      ien_q <= '0;
    end else begin
      if (wr_sel) sel_q <= wr_data[1:0];
      if (wr_act) act_q <= wr_data[ACT_W-1:0];
      if (wr_ien) ien_q <= wr_data[1:0];
    end
  end

  trip_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .pin_n(trip_n), .fault(fault)
  );

  trip_core core_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fault    (fault),
    .sel_cyc  (sel_q[BIT_CYC]),
    .sel_os   (sel_q[BIT_OS]),
    .ie_cyc   (ien_q[BIT_CYC]),
    .ie_os    (ien_q[BIT_OS]),
    .frc_cyc  (wr_frc & wr_data[BIT_CYC]),
    .frc_os   (wr_frc & wr_data[BIT_OS]),
    .clr_cyc  (wr_clr & wr_data[BIT_CYC]),
    .clr_os   (wr_clr & wr_data[BIT_OS]),
    .clr_irq  (wr_clr & wr_data[BIT_IRQ]),
    .ctr_zero (ctr_zero),
    .os_state (os_state),
    .cyc_state(cyc_state),
    .cyc_flag (cyc_flag),
    .irq      (irq)
  );

  assign tripped = os_state | cyc_state;
  assign pin_v   = {pwm_b_in, pwm_a_in};

  genvar g;
  generate
    for (g = 0; g < NUM_OUT; g++) begin : g_out
      trip_out_stage stage_i (
        .tripped(tripped),
        .act    (act_q[2*g +: 2]),
        .pwm_in (pin_v[g]),
        .pwm_out(out_v[g]),
        .pwm_oe (oe_v[g])
      );
    end
  endgenerate

  assign pwm_a_out = out_v[0];
  assign pwm_a_oe  = oe_v[0];
  assign pwm_b_out = out_v[1];
  assign pwm_b_oe  = oe_v[1];
  assign os_flag   = os_state;
endmodule

// File: rtl/pwm_trip_guard_chk.sv
module pwm_trip_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [3:0] wr_data,
  input logic       ctr_zero,
  input logic       pwm_a_oe,
  input logic       pwm_b_oe,
  input logic       os_flag,
  input logic       cyc_flag,
  input logic       irq,
  input logic       cyc_state
);
  logic clr_w;
  assign clr_w = wr_en && (wr_addr == 3'd3);

  // R3
  os_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    os_flag && !(clr_w && wr_data[1]) |=> os_flag);

  // R7
  cyc_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_flag && !(clr_w && wr_data[0]) |=> cyc_flag);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(clr_w && wr_data[2]) |=> irq);

  // R4
  cyc_release_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cyc_state) |-> $past(ctr_zero));

  // R5
  hiz_only_when_tripped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_a_oe || !pwm_b_oe) |-> (os_flag || cyc_state));
endmodule

bind pwm_trip_guard pwm_trip_guard_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .ctr_zero (ctr_zero),
  .pwm_a_oe (pwm_a_oe),
  .pwm_b_oe (pwm_b_oe),
  .os_flag  (os_flag),
  .cyc_flag (cyc_flag),
  .irq      (irq),
  .cyc_state(cyc_state)
);

// File: tb/pwm_trip_guard_tb_top.sv
module pwm_trip_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_a_in = 1'b0, pwm_b_in = 1'b0, trip_n = 1'b1, ctr_zero = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic pwm_a_out, pwm_a_oe, pwm_b_out, pwm_b_oe, os_flag, cyc_flag, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pwm_trip_guard dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_a_in(pwm_a_in), .pwm_b_in(pwm_b_in),
    .trip_n(trip_n), .ctr_zero(ctr_zero), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_a_out(pwm_a_out), .pwm_a_oe(pwm_a_oe),
    .pwm_b_out(pwm_b_out), .pwm_b_oe(pwm_b_oe), .os_flag(os_flag),
    .cyc_flag(cyc_flag), .irq(irq)
  );

  // {action code[1:0], pwm in, expected out, expected oe}
  localparam logic [4:0] VEC [8] = '{
    5'b00_0_0_0, 5'b00_1_0_0, 5'b01_0_1_1, 5'b01_1_1_1,
    5'b10_0_0_1, 5'b10_1_0_1, 5'b11_0_0_1, 5'b11_1_1_1
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic zero_pulse();
    ctr_zero = 1'b1; tick(); ctr_zero = 1'b0;
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // {a_out, a_oe, b_out, b_oe}
  function automatic logic [3:0] outs();
    return {pwm_a_out, pwm_a_oe, pwm_b_out, pwm_b_oe};
  endfunction

  function automatic logic [3:0] flags();
    return {1'b0, os_flag, cyc_flag, irq};
  endfunction

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state: pass-through, flags clear
    pwm_a_in = 1'b1; pwm_b_in = 1'b0; #1;
    chk("R1 outputs", outs(), 4'b1101);
    chk("R1 flags", flags(), 4'b0000);

    // R10 force one-shot with no select, then R5 table walk
    wr(3'd4, 4'b0010);
    chk("R10 force one-shot", flags(), 4'b0100);
    for (int i = 0; i < 8; i++) begin
      wr(3'd1, {VEC[i][4:3], VEC[i][4:3]});
      pwm_a_in = VEC[i][2]; pwm_b_in = VEC[i][2]; #1;
      chk("R5 action", outs(), {VEC[i][1:0], VEC[i][1:0]});
    end
    wr(3'd3, 4'b0000);
    chk("R7 write zero clears nothing", flags(), 4'b0100);
    wr(3'd3, 4'b0010);
    chk("R3 one-shot clear", flags(), 4'b0000);
    chk("R3 released outputs", outs(), 4'b1111);

    // R6 pin ignored with no select; action 0 would drop oe
    wr(3'd1, 4'b0000);
    pwm_a_in = 1'b0; pwm_b_in = 1'b1;
    trip_n = 1'b0;
    repeat (5) tick();
    chk("R6 outputs", outs(), 4'b0111);
    chk("R6 flags", flags(), 4'b0000);
    trip_n = 1'b1;
    repeat (3) tick();

    // R2 latency and R3 latching; A high, B low
    wr(3'd0, 4'b0010);
    wr(3'd1, 4'b1001);
    pwm_a_in = 1'b0; pwm_b_in = 1'b1;
    trip_n = 1'b0;
    tick(); tick();
    chk("R2 not yet tripped", outs(), 4'b0111);
    tick();
    chk("R2 tripped on third edge", outs(), 4'b1101);
    trip_n = 1'b1;
    repeat (3) tick();
    zero_pulse();
    chk("R3 latched after pin idle", outs(), 4'b1101);
    wr(3'd3, 4'b0010);
    chk("R3 released by clear", outs(), 4'b0111);

    // R4 cycle-by-cycle behaviour
    wr(3'd0, 4'b0001);
    trip_n = 1'b0;
    repeat (3) tick();
    chk("R4 tripped", outs(), 4'b1101);
    chk("R7 flag set", flags(), 4'b0010);
    zero_pulse();
    chk("R4 held while pin low", outs(), 4'b1101);
    trip_n = 1'b1;
    repeat (3) tick();
    chk("R4 held until zero", outs(), 4'b1101);
    zero_pulse();
    chk("R4 released at zero", outs(), 4'b0111);
    chk("R7 flag survives release", flags(), 4'b0010);
    wr(3'd3, 4'b0001);
    chk("R7 flag cleared", flags(), 4'b0000);

    // R8 and R9 interrupt
    wr(3'd0, 4'b0000);
    wr(3'd2, 4'b0010);
    wr(3'd4, 4'b0001);
    chk("R8 disabled event no irq", flags(), 4'b0010);
    chk("R10 force cycle trips outputs", outs(), 4'b1101);
    zero_pulse();
    wr(3'd3, 4'b0001);
    wr(3'd4, 4'b0010);
    chk("R8 enabled event irq", flags(), 4'b0101);
    wr(3'd3, 4'b0010);
    chk("R9 irq held after flag clear", flags(), 4'b0001);
    wr(3'd3, 4'b0100);
    chk("R9 irq cleared", flags(), 4'b0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule